// File: doc/BRIEF.md
# SPI Command Response Checker

This block sits on the host side of a byte-oriented SPI link. It examines the reply that a peripheral returns after the host has issued a command frame. The host pulses `cmd_start` with the opcode it has just sent, the DMA byte count and the CRC-enable setting. Received bytes then arrive one per clock, each marked by `rx_valid`. While the reply is being clocked in, the outgoing byte is held at zero.

The checker first drops a filler byte when the opcode calls for one. It then verifies the command echo and the status byte. For read opcodes it searches for a data-start header. A single-word read is assembled into a 32-bit word. A DMA read is forwarded byte by byte as a payload stream. The trailing check bytes that follow a data block are consumed and never forwarded. The outcome is reported as a one-cycle `done` pulse carrying ok, fail or resynchronise. Checking the value of the CRC bytes is outside this block.

Top module: `spi_rsp_checker`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `busy`, `done`, `result`, `rd_word_valid`, `pl_valid` and `pl_last` are all zero.
- R2: `cmd_start` is taken only when `busy` is low, and `busy` is high from the next cycle. A received byte in the cycle of an accepted start is ignored, as is a start while busy. Bytes that arrive while idle produce no output.
- R3: `tx_byte` is 0x00 in every cycle.
- R4: For opcodes 0xC5, 0xC6 and 0xCF, the first received byte after the start is discarded before the echo check. For all other opcodes, the first byte is the echo.
- R5: If the echo byte differs from the opcode, the block ends with result fail.
- R6: The byte after the echo is the status byte. If it is nonzero, the result is fail. If it is zero and the opcode is not a read (0xC4, 0xCA, 0xC2, 0xC8), the result is ok.
- R7: For read opcodes, the block scans the bytes after the status byte for one whose upper nibble is 0xF. It examines at most `FIRST_HUNT` bytes. If none of them is a header, the result is resync.
- R8: For 0xC4 and 0xCA, the 4 bytes after the header form `rd_word`, first byte most significant. `rd_word_valid` pulses together with an ok `done`.
- R9: When `crc_en` was set at the start, 2 bytes follow each data block or word. These bytes are consumed and never forwarded or interpreted as headers, and the ok result comes only after the second of them.
- R10: For 0xC2 and 0xC8, exactly `cmd_size` payload bytes are forwarded in the order received, one cycle after each arrives. `pl_last` is set only on the final byte.
- R11: DMA payload is split into blocks of at most `BLOCK_BYTES` bytes. Every block after the first is preceded by its own header search of at most `NEXT_HUNT` bytes. If that search fails, the result is fail.
- R12: `done` is a one-cycle pulse in the cycle after the deciding byte, and `busy` is low in that same cycle. The result codes are 1 for ok, 2 for fail and 3 for resync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Begin checking the reply to the command just sent |
| cmd_op | input | 8 | Opcode that was issued |
| cmd_size | input | SIZE_W | DMA read byte count |
| crc_en | input | 1 | Data blocks carry 2 trailing check bytes |
| rx_valid | input | 1 | A received byte is present |
| rx_byte | input | 8 | Received byte |
| tx_byte | output | 8 | Outgoing filler byte |
| busy | output | 1 | A reply is being checked |
| done | output | 1 | Result pulse |
| result | output | 2 | 1 ok, 2 fail, 3 resync; valid with done |
| rd_word | output | 32 | Assembled single-word read data |
| rd_word_valid | output | 1 | rd_word is fresh |
| pl_valid | output | 1 | Payload byte present |
| pl_data | output | 8 | Payload byte |
| pl_last | output | 1 | Final payload byte of the transfer |

## Verification
The assertions assume three things about the inputs. First, `cmd_size` is at least 1 for DMA reads. Second, at most one received byte arrives per clock. Third, the host does not begin a new reply until the current one has ended. The stimulus builds every reply frame from the opcode it announced and only ever uses nonzero DMA sizes. It pulses a second start during a busy reply only to show that the start is ignored. It inserts idle cycles between bytes to show that only cycles marked valid advance the checker.

// File: rtl/spi_rsp_pkg.sv
package spi_rsp_pkg;

    localparam int WORD_BYTES = 4;
    localparam int CRC_BYTES  = 2;

    localparam logic [7:0] OP_DMA_RD     = 8'hC2;
    localparam logic [7:0] OP_REG_RD     = 8'hC4;
    localparam logic [7:0] OP_END        = 8'hC5;
    localparam logic [7:0] OP_AGAIN      = 8'hC6;
    localparam logic [7:0] OP_DMA_XRD    = 8'hC8;
    localparam logic [7:0] OP_WORD_RD    = 8'hCA;
    localparam logic [7:0] OP_RESTART    = 8'hCF;

    typedef enum logic [1:0] {
        RES_NONE  = 2'd0,
        RES_OK    = 2'd1,
        RES_FAIL  = 2'd2,
        RES_RESYNC = 2'd3
    } rsp_res_e;

    typedef enum logic [1:0] {
        CL_PLAIN,
        CL_SKIP,
        CL_WORD,
        CL_DMA
    } op_class_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SKIP,
        ST_ECHO,
        ST_STAT,
        ST_HUNT,
        ST_WORD,
        ST_DMA,
        ST_CHK
    } rsp_state_e;

    function automatic op_class_e op_class(input logic [7:0] op);
        case (op)
            OP_END, OP_AGAIN, OP_RESTART: return CL_SKIP;
            OP_REG_RD, OP_WORD_RD:        return CL_WORD;
            OP_DMA_RD, OP_DMA_XRD:        return CL_DMA;
            default:                      return CL_PLAIN;
        endcase
    endfunction

    function automatic logic is_hdr(input logic [7:0] b);
        return b[7:4] == 4'hF;
    endfunction

endpackage

// File: rtl/spi_rsp_ctrl.sv
module spi_rsp_ctrl
    import spi_rsp_pkg::*;
#(
    parameter int FIRST_HUNT = 16,
    parameter int NEXT_HUNT  = 11
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic [7:0] op_i,
    input  logic       crc_en_i,
    input  logic       rx_valid_i,
    input  logic [7:0] rx_byte_i,
    input  logic       blk_end_i,
    input  logic       xfer_end_i,
    output logic       busy_o,
    output logic       word_shift_o,
    output logic       pay_fire_o,
    output logic       size_load_o,
    output logic       blk_clear_o,
    output logic       done_o,
    output rsp_res_e   res_o,
    output logic       word_done_o
);

    localparam int HUNT_MAX = (FIRST_HUNT > NEXT_HUNT) ? FIRST_HUNT : NEXT_HUNT;
    localparam int HUNT_W   = $clog2(HUNT_MAX) + 1;
    localparam int IDX_W    = $clog2(WORD_BYTES);

    rsp_state_e         st_q;
    op_class_e          cls_q;
    logic [7:0]         op_q;
    logic               crc_q;
    logic               first_q;
    logic               fin_q;
    logic [HUNT_W-1:0]  hunt_q;
    logic [IDX_W-1:0]   idx_q;
    logic               done_q;
    rsp_res_e           res_q;
    logic               word_done_q;

    // Per-byte strobes towards the datapath neighbours
    always_comb begin
        busy_o       = (st_q != ST_IDLE);
        size_load_o  = (st_q == ST_IDLE) && start_i;
        word_shift_o = (st_q == ST_WORD) && rx_valid_i;
        pay_fire_o   = (st_q == ST_DMA) && rx_valid_i;
        blk_clear_o  = (st_q == ST_HUNT) && rx_valid_i && is_hdr(rx_byte_i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_IDLE;
            cls_q       <= CL_PLAIN;
            op_q        <= 8'h00;
            crc_q       <= 1'b0;
            first_q     <= 1'b0;
            fin_q       <= 1'b0;
            hunt_q      <= '0;
            idx_q       <= '0;
            done_q      <= 1'b0;
            res_q       <= RES_NONE;
            word_done_q <= 1'b0;
        end else begin
            done_q      <= 1'b0;
            res_q       <= RES_NONE;
            word_done_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (start_i) begin
                        op_q    <= op_i;
                        cls_q   <= op_class(op_i);
                        crc_q   <= crc_en_i;
                        first_q <= 1'b1;
                        fin_q   <= 1'b0;
                        idx_q   <= '0;
                        st_q    <= (op_class(op_i) == CL_SKIP) ? ST_SKIP : ST_ECHO;
                    end
                end
                ST_SKIP: begin
                    if (rx_valid_i) st_q <= ST_ECHO;
                end
                ST_ECHO: begin
                    if (rx_valid_i) begin
                        if (rx_byte_i != op_q) begin
                            done_q <= 1'b1;
                            res_q  <= RES_FAIL;
                            st_q   <= ST_IDLE;
                        end else begin
                            st_q <= ST_STAT;
                        end
                    end
                end
                ST_STAT: begin
                    if (rx_valid_i) begin
                        if (rx_byte_i != 8'h00) begin
                            done_q <= 1'b1;
                            res_q  <= RES_FAIL;
                            st_q   <= ST_IDLE;
                        end else if (cls_q == CL_WORD || cls_q == CL_DMA) begin
                            st_q   <= ST_HUNT;
                            hunt_q <= HUNT_W'(FIRST_HUNT - 1);
                        end else begin
                            done_q <= 1'b1;
                            res_q  <= RES_OK;
                            st_q   <= ST_IDLE;
                        end
                    end
                end
                ST_HUNT: begin
                    if (rx_valid_i) begin
                        if (is_hdr(rx_byte_i)) begin
                            st_q  <= (cls_q == CL_WORD) ? ST_WORD : ST_DMA;
                            idx_q <= '0;
                        end else if (hunt_q == '0) begin
                            done_q <= 1'b1;
                            res_q  <= first_q ? RES_RESYNC : RES_FAIL;
                            st_q   <= ST_IDLE;
                        end else begin
                            hunt_q <= hunt_q - HUNT_W'(1);
                        end
                    end
                end
                ST_WORD: begin
                    if (rx_valid_i) begin
                        idx_q <= idx_q + IDX_W'(1);
                        if (idx_q == IDX_W'(WORD_BYTES - 1)) begin
                            fin_q <= 1'b1;
                            idx_q <= '0;
                            if (crc_q) begin
                                st_q <= ST_CHK;
                            end else begin
                                done_q      <= 1'b1;
                                res_q       <= RES_OK;
                                word_done_q <= 1'b1;
                                st_q        <= ST_IDLE;
                            end
                        end
                    end
                end
                ST_DMA: begin
                    if (rx_valid_i) begin
                        if (xfer_end_i) begin
                            fin_q <= 1'b1;
                            if (crc_q) begin
                                st_q  <= ST_CHK;
                                idx_q <= '0;
                            end else begin
                                done_q <= 1'b1;
                                res_q  <= RES_OK;
                                st_q   <= ST_IDLE;
                            end
                        end else if (blk_end_i) begin
                            if (crc_q) begin
                                st_q  <= ST_CHK;
                                idx_q <= '0;
                            end else begin
                                st_q    <= ST_HUNT;
                                hunt_q  <= HUNT_W'(NEXT_HUNT - 1);
                                first_q <= 1'b0;
                            end
                        end
                    end
                end
                ST_CHK: begin
                    if (rx_valid_i) begin
                        idx_q <= idx_q + IDX_W'(1);
                        if (idx_q == IDX_W'(CRC_BYTES - 1)) begin
                            if (fin_q) begin
                                done_q      <= 1'b1;
                                res_q       <= RES_OK;
                                word_done_q <= (cls_q == CL_WORD);
                                st_q        <= ST_IDLE;
                            end else begin
                                st_q    <= ST_HUNT;
                                hunt_q  <= HUNT_W'(NEXT_HUNT - 1);
                                first_q <= 1'b0;
                            end
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign done_o      = done_q;
    assign res_o       = res_q;
    assign word_done_o = word_done_q;

endmodule

// File: rtl/spi_rsp_word.sv
module spi_rsp_word
    import spi_rsp_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    shift_i,
    input  logic [7:0]              byte_i,
    output logic [8*WORD_BYTES-1:0] word_o
);

    logic [7:0] lane [WORD_BYTES];

    // Lane 0 takes the newest byte; the oldest ends up in the top lane
    for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
        if (g == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst)          lane[g] <= 8'h00;
                else if (shift_i) lane[g] <= byte_i;
            end
        end else begin : g_tail
            always_ff @(posedge clk) begin
                if (rst)          lane[g] <= 8'h00;
                else if (shift_i) lane[g] <= lane[g-1];
            end
        end
        assign word_o[8*g +: 8] = lane[g];
    end

endmodule

// File: rtl/spi_rsp_payload.sv
module spi_rsp_payload #(
    parameter int SIZE_W      = 24,
    parameter int BLOCK_BYTES = 8192
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              size_load_i,
    input  logic [SIZE_W-1:0] size_i,
    input  logic              blk_clear_i,
    input  logic              fire_i,
    input  logic [7:0]        byte_i,
    output logic              blk_end_o,
    output logic              xfer_end_o,
    output logic              pl_valid_o,
    output logic [7:0]        pl_data_o,
    output logic              pl_last_o
);

    localparam int BLK_W = $clog2(BLOCK_BYTES + 1);

    logic [SIZE_W-1:0] remain_q;
    logic [BLK_W-1:0]  blk_q;

    assign xfer_end_o = (remain_q <= SIZE_W'(1));
    assign blk_end_o  = (blk_q == BLK_W'(BLOCK_BYTES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= '0;
            blk_q    <= '0;
        end else begin
            if (size_load_i) begin
                remain_q <= size_i;
            end else if (fire_i) begin
                remain_q <= remain_q - SIZE_W'(1);
            end
            if (blk_clear_i) begin
                blk_q <= '0;
            end else if (fire_i) begin
                blk_q <= blk_q + BLK_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pl_valid_o <= 1'b0;
            pl_data_o  <= 8'h00;
            pl_last_o  <= 1'b0;
        end else begin
            pl_valid_o <= fire_i;
            pl_last_o  <= fire_i && xfer_end_o;
            if (fire_i) pl_data_o <= byte_i;
        end
    end

endmodule

// File: rtl/spi_rsp_checker.sv
module spi_rsp_checker
    import spi_rsp_pkg::*;
#(
    parameter int SIZE_W      = 24,
    parameter int BLOCK_BYTES = 8192,
    parameter int FIRST_HUNT  = 16,
    parameter int NEXT_HUNT   = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_start,
    input  logic [7:0]        cmd_op,
    input  logic [SIZE_W-1:0] cmd_size,
    input  logic              crc_en,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    output logic [7:0]        tx_byte,
    output logic              busy,
    output logic              done,
    output logic [1:0]        result,
    output logic [31:0]       rd_word,
    output logic              rd_word_valid,
    output logic              pl_valid,
    output logic [7:0]        pl_data,
    output logic              pl_last
);

    logic     word_shift;
    logic     pay_fire;
    logic     size_load;
    logic     blk_clear;
    logic     blk_end;
    logic     xfer_end;
    rsp_res_e res;

    assign tx_byte = 8'h00;
    assign result  = res;

    spi_rsp_ctrl #(
        .FIRST_HUNT (FIRST_HUNT),
        .NEXT_HUNT  (NEXT_HUNT)
    ) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start_i      (cmd_start),
        .op_i         (cmd_op),
        .crc_en_i     (crc_en),
        .rx_valid_i   (rx_valid),
        .rx_byte_i    (rx_byte),
        .blk_end_i    (blk_end),
        .xfer_end_i   (xfer_end),
        .busy_o       (busy),
        .word_shift_o (word_shift),
        .pay_fire_o   (pay_fire),
        .size_load_o  (size_load),
        .blk_clear_o  (blk_clear),
        .done_o       (done),
        .res_o        (res),
        .word_done_o  (rd_word_valid)
    );

    spi_rsp_word u_word (
        .clk     (clk),
        .rst     (rst),
        .shift_i (word_shift),
        .byte_i  (rx_byte),
        .word_o  (rd_word)
    );

    spi_rsp_payload #(
        .SIZE_W      (SIZE_W),
        .BLOCK_BYTES (BLOCK_BYTES)
    ) u_pay (
        .clk         (clk),
        .rst         (rst),
        .size_load_i (size_load),
        .size_i      (cmd_size),
        .blk_clear_i (blk_clear),
        .fire_i      (pay_fire),
        .byte_i      (rx_byte),
        .blk_end_o   (blk_end),
        .xfer_end_o  (xfer_end),
        .pl_valid_o  (pl_valid),
        .pl_data_o   (pl_data),
        .pl_last_o   (pl_last)
    );

endmodule

// File: rtl/spi_rsp_sva.sv
module spi_rsp_sva (
    input logic       clk,
    input logic       rst,
    input logic       cmd_start,
    input logic       rx_valid,
    input logic       busy,
    input logic       done,
    input logic [1:0] result,
    input logic       rd_word_valid,
    input logic       pl_valid,
    input logic       pl_last
);

    p_start_busy_r2: assert property (@(posedge clk) disable iff (rst)
        (cmd_start && !busy) |=> busy);

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !busy |=> (!pl_valid && !done));

    p_word_ok_r8: assert property (@(posedge clk) disable iff (rst)
        rd_word_valid |-> (done && result == 2'd1));

    p_last_valid_r10: assert property (@(posedge clk) disable iff (rst)
        pl_last |-> pl_valid);

    p_pay_src_r10: assert property (@(posedge clk) disable iff (rst)
        pl_valid |-> ($past(rx_valid) && $past(busy)));

    p_done_code_r12: assert property (@(posedge clk) disable iff (rst)
        done |-> (result != 2'd0));

    p_done_idle_r12: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    p_done_pulse_r12: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

bind spi_rsp_checker spi_rsp_sva u_sva (
    .clk           (clk),
    .rst           (rst),
    .cmd_start     (cmd_start),
    .rx_valid      (rx_valid),
    .busy          (busy),
    .done          (done),
    .result        (result),
    .rd_word_valid (rd_word_valid),
    .pl_valid      (pl_valid),
    .pl_last       (pl_last)
);

// File: tb/spi_rsp_checker_tb_top.sv
module spi_rsp_checker_tb_top;

    localparam int SZW = 24;
    localparam int BLK = 5;
    localparam int H1  = 16;
    localparam int H2  = 11;
    localparam logic [1:0] OK = 2'd1, FL = 2'd2, RS = 2'd3;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic           rst;
    logic           cmd_start;
    logic [7:0]     cmd_op;
    logic [SZW-1:0] cmd_size;
    logic           crc_en;
    logic           rx_valid;
    logic [7:0]     rx_byte;
    logic [7:0]     tx_byte;
    logic           busy, done, rd_word_valid, pl_valid, pl_last;
    logic [1:0]     result;
    logic [31:0]    rd_word;
    logic [7:0]     pl_data;

    spi_rsp_checker #(
        .SIZE_W (SZW), .BLOCK_BYTES (BLK), .FIRST_HUNT (H1), .NEXT_HUNT (H2)
    ) dut_i (
        .clk (clk), .rst (rst), .cmd_start (cmd_start), .cmd_op (cmd_op),
        .cmd_size (cmd_size), .crc_en (crc_en), .rx_valid (rx_valid),
        .rx_byte (rx_byte), .tx_byte (tx_byte), .busy (busy), .done (done),
        .result (result), .rd_word (rd_word), .rd_word_valid (rd_word_valid),
        .pl_valid (pl_valid), .pl_data (pl_data), .pl_last (pl_last)
    );

    // One entry per clock: the inputs to apply and the outputs expected after the edge
    typedef struct {
        bit             s;
        logic [7:0]     sop;
        logic [SZW-1:0] sz;
        bit             crc;
        bit             v;
        logic [7:0]     b;
        bit             busy;
        bit             pv;
        logic [7:0]     pd;
        bit             pl;
        bit             dv;
        logic [1:0]     res;
        bit             wv;
        logic [31:0]    w;
        int             tag;
    } step_t;

    step_t q[$];
    int n_chk = 0;
    int n_bad = 0;
    bit ended = 0;

    function automatic step_t blank(int tag);
        step_t x;
        x.s = 0; x.sop = 8'h00; x.sz = '0; x.crc = 0; x.v = 0; x.b = 8'h00;
        x.busy = 1; x.pv = 0; x.pd = 8'h00; x.pl = 0; x.dv = 0; x.res = 2'd0;
        x.wv = 0; x.w = 32'h0; x.tag = tag;
        return x;
    endfunction

    task automatic s_start(logic [7:0] op, int sz, bit crc, int tag);
        step_t x = blank(tag);
        x.s = 1; x.sop = op; x.sz = SZW'(sz); x.crc = crc; x.v = 1; x.b = op;
        q.push_back(x);
    endtask

    task automatic s_start_busy(logic [7:0] op, int tag);
        step_t x = blank(tag);
        x.s = 1; x.sop = op;
        q.push_back(x);
    endtask

    task automatic s_in(logic [7:0] b, int tag);
        step_t x = blank(tag);
        x.v = 1; x.b = b;
        q.push_back(x);
    endtask

    task automatic s_gap(int tag);
        step_t x = blank(tag);
        q.push_back(x);
    endtask

    task automatic s_idle(logic [7:0] b, int tag);
        step_t x = blank(tag);
        x.v = 1; x.b = b; x.busy = 0;
        q.push_back(x);
    endtask

    task automatic s_pay(logic [7:0] b, bit last, int tag);
        step_t x = blank(tag);
        x.v = 1; x.b = b; x.pv = 1; x.pd = b; x.pl = last;
        q.push_back(x);
    endtask

    task automatic s_end(logic [7:0] b, logic [1:0] res, int tag);
        step_t x = blank(tag);
        x.v = 1; x.b = b; x.busy = 0; x.dv = 1; x.res = res;
        q.push_back(x);
    endtask

    task automatic s_pay_end(logic [7:0] b, int tag);
        step_t x = blank(tag);
        x.v = 1; x.b = b; x.busy = 0; x.pv = 1; x.pd = b; x.pl = 1;
        x.dv = 1; x.res = OK;
        q.push_back(x);
    endtask

    task automatic s_word_end(logic [7:0] b, logic [31:0] w, int tag);
        step_t x = blank(tag);
        x.v = 1; x.b = b; x.busy = 0; x.dv = 1; x.res = OK; x.wv = 1; x.w = w;
        q.push_back(x);
    endtask

    task automatic check(step_t x);
        bit ok;
        n_chk++;
        if (tx_byte !== 8'h00) begin
            n_bad++;
            $display("FAIL R3: tx_byte got %h expected 00", tx_byte);
        end
        n_chk++;
        ok = (busy === x.busy) && (pl_valid === x.pv) && (pl_last === x.pl)
          && (!x.pv || pl_data === x.pd) && (done === x.dv)
          && (!x.dv || result === x.res) && (rd_word_valid === x.wv)
          && (!x.wv || rd_word === x.w);
        if (!ok) begin
            n_bad++;
            $display("FAIL R%0d: busy %b/%b pv %b/%b data %h/%h last %b/%b done %b/%b res %0d/%0d wv %b/%b word %h/%h (actual/expected)",
                     x.tag, busy, x.busy, pl_valid, x.pv, pl_data, x.pd, pl_last, x.pl,
                     done, x.dv, result, x.res, rd_word_valid, x.wv, rd_word, x.w);
        end
    endtask

    task automatic run_queue();
        while (q.size() > 0) begin
            step_t x = q.pop_front();
            cmd_start = x.s;
            cmd_op    = x.sop;
            if (x.s) begin
                cmd_size = x.sz;
                crc_en   = x.crc;
            end
            rx_valid = x.v;
            rx_byte  = x.b;
            @(posedge clk);
            @(negedge clk);
            check(x);
        end
        cmd_start = 0;
        rx_valid  = 0;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not complete (actual hung, expected finished)");
        finish_run();
    end

    initial begin
        rst = 1; cmd_start = 0; cmd_op = 0; cmd_size = '0; crc_en = 0;
        rx_valid = 0; rx_byte = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1: idle outputs right after reset
        begin
            step_t x = blank(1);
            x.busy = 0;
            q.push_back(x);
        end
        // R2: bytes while idle have no effect
        s_idle(8'hC9, 2);
        s_idle(8'hF0, 2);

        // R6: plain write ends ok after zero status, with gaps (R2)
        s_start(8'hC9, 0, 1, 6);
        s_gap(2);
        s_in(8'hC9, 6);
        s_gap(2);
        s_end(8'h00, OK, 6);
        s_idle(8'hC9, 2);

        // R4: restart opcode drops one byte first
        s_start(8'hCF, 0, 0, 4);
        s_in(8'hFF, 4);
        s_in(8'hCF, 4);
        s_end(8'h00, OK, 4);
        // R4: terminate, dropped byte does not match the opcode
        s_start(8'hC5, 0, 0, 4);
        s_in(8'h00, 4);
        s_in(8'hC5, 4);
        s_end(8'h00, OK, 4);

        // R5: echo mismatch fails, later bytes ignored
        s_start(8'hC3, 0, 0, 5);
        s_end(8'hC4, FL, 5);
        s_idle(8'h00, 2);
        s_idle(8'hC3, 2);

        // R6: nonzero status fails
        s_start(8'hC1, 0, 0, 6);
        s_in(8'hC1, 6);
        s_end(8'h01, FL, 6);

        // R2: start while busy is ignored
        s_start(8'hC9, 0, 0, 2);
        s_start_busy(8'hCA, 2);
        s_in(8'hC9, 2);
        s_end(8'h00, OK, 2);

        // R8 with R7: word read, two junk bytes before header
        s_start(8'hCA, 0, 0, 8);
        s_in(8'hCA, 8);
        s_in(8'h00, 8);
        s_in(8'hEF, 7);
        s_in(8'h00, 7);
        s_in(8'hF3, 7);
        s_in(8'h12, 8);
        s_gap(8);
        s_in(8'h34, 8);
        s_in(8'h56, 8);
        s_word_end(8'h78, 32'h12345678, 8);

        // R9: word read with check bytes that look like headers
        s_start(8'hC4, 0, 1, 9);
        s_in(8'hC4, 9);
        s_in(8'h00, 9);
        s_in(8'hF0, 9);
        s_in(8'hA1, 9);
        s_in(8'hB2, 9);
        s_in(8'hC3, 9);
        s_in(8'hD4, 9);
        s_in(8'hF5, 9);
        s_word_end(8'h9E, 32'hA1B2C3D4, 9);

        // R7: header as the last byte of the first search window
        s_start(8'hC4, 0, 0, 7);
        s_in(8'hC4, 7);
        s_in(8'h00, 7);
        for (int i = 0; i < H1 - 1; i++) s_in(8'hE0, 7);
        s_in(8'hF1, 7);
        s_in(8'h01, 8);
        s_in(8'h02, 8);
        s_in(8'h03, 8);
        s_word_end(8'h04, 32'h01020304, 8);

        // R7: no header in the first window gives resync
        s_start(8'hCA, 0, 0, 7);
        s_in(8'hCA, 7);
        s_in(8'h00, 7);
        for (int i = 0; i < H1 - 1; i++) s_in(8'h0F, 7);
        s_end(8'h0F, RS, 7);
        s_idle(8'hF0, 2);

        // R10, R11, R9: 12-byte DMA read over three blocks with check bytes
        s_start(8'hC8, 12, 1, 10);
        s_in(8'hC8, 10);
        s_in(8'h00, 10);
        s_in(8'h00, 7);
        s_in(8'hFF, 7);
        for (int i = 1; i <= 5; i++) s_pay(8'h40 + 8'(i), 0, 10);
        s_in(8'hF7, 9);
        s_gap(9);
        s_in(8'hF8, 9);
        for (int i = 0; i < H2 - 1; i++) s_in(8'h11, 11);
        s_in(8'hF0, 11);
        for (int i = 6; i <= 10; i++) s_pay(8'h40 + 8'(i), 0, 11);
        s_in(8'h00, 9);
        s_in(8'h00, 9);
        s_in(8'hFA, 11);
        s_pay(8'hF1, 0, 10);
        s_pay(8'h4C, 1, 10);
        s_in(8'hFE, 9);
        s_end(8'hFD, OK, 9);

        // R10: short DMA read, single block, no check bytes
        s_start(8'hC2, 3, 0, 10);
        s_in(8'hC2, 10);
        s_in(8'h00, 10);
        s_in(8'hF0, 10);
        s_pay(8'hF1, 0, 10);
        s_gap(10);
        s_pay(8'h22, 0, 10);
        s_pay_end(8'h33, 10);

        // R11: transfer exactly one block long, with check bytes
        s_start(8'hC2, BLK, 1, 11);
        s_in(8'hC2, 11);
        s_in(8'h00, 11);
        s_in(8'hF0, 11);
        for (int i = 0; i < BLK - 1; i++) s_pay(8'h60 + 8'(i), 0, 11);
        s_pay(8'h6F, 1, 11);
        s_in(8'h12, 9);
        s_end(8'h34, OK, 9);

        // R11: later block without header within its window fails
        s_start(8'hC8, 7, 0, 11);
        s_in(8'hC8, 11);
        s_in(8'h00, 11);
        s_in(8'hF0, 11);
        for (int i = 0; i < BLK; i++) s_pay(8'h70 + 8'(i), 0, 11);
        for (int i = 0; i < H2 - 1; i++) s_in(8'h05, 11);
        s_end(8'h05, FL, 11);
        s_idle(8'hF0, 12);

        run_queue();
        repeat (2) @(posedge clk);
        finish_run();
    end

endmodule